// File: doc/BRIEF.md
# Table-Decoded Gated Clock Divider

This block produces a divided clock from a single fast source clock. A control word holds a four-bit selector and a disable bit. The selector does not hold the divisor itself. It picks one of ten divisors from a fixed, sparse set: 3, 4, 6, 8, 12, 16, 18, 24, 36 and 48. Software writes the control word through a plain register port in the source clock domain and can read back the stored selector, the disable bit and a sticky error flag.

The output is built from registers and is free of glitches. A new divisor, and any change to the gate, takes effect only where one output period ends and the next begins. A period therefore never gets cut short, and the clock never stops in the middle of a high phase. A one-cycle `period_tick` pulse marks the first source cycle of each output period. Downstream logic can use it as a clock enable, and a bench can use it to find period boundaries. The register port is a plain write strobe with combinational readback. It has no handshake and applies no back-pressure.

Top module: `table_clk_div`

## Requirements
- R1: After reset, `rd_data` reads 0x0101 (disabled, selector 1), and `clk_out` and `period_tick` stay low.
- R2: The selector sits in `wr_data[3:0]`. Selector values 1, 2, 3 and 4 divide by 3, 4, 6 and 8.
- R3: Selector values 5, 6, 7 and 8 divide by 12, 16, 18 and 24. Value 10 divides by 36 and value 11 divides by 48.
- R4: A write whose selector is 0, 9 or 12 to 15 is ignored as a whole. The stored selector and the disable bit keep their values, and the clock continues at its old divisor.
- R5: An ignored write sets an error flag that is read at `rd_data[15]` and stays set until reset. The readback layout is error in bit 15, disable in bit 8 and selector in bits 3:0. All other bits read zero.
- R6: For a divisor N, `clk_out` is high for floor(N/2) source cycles and then low for the rest of the period. For N=3 this is one cycle high and two cycles low.
- R7: A new divisor takes effect only after the current output period has finished at its old length.
- R8: Writing 1 to bit 8 stops the clock at the end of the current period. After that, `clk_out` stays low and `period_tick` does not pulse.
- R9: Writing 0 to bit 8 restarts the clock with a full-length first period.
- R10: `period_tick` is high for exactly one source cycle per output period, and that cycle is the first high cycle of `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write: selector [3:0], disable [8] |
| rd_data | output | 16 | Readback: selector, disable, sticky error |
| clk_out | output | 1 | Divided, gated clock |
| period_tick | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The bench steps through all sixteen selector values and measures the period, the high time and the tick count for each one. A wrong table entry would show up as a wrong period length. An invalid code that got through would show up as a changed readback or a changed period. It reprograms the divisor in the middle of a period, in both directions between 48 and 3. A design that loads the divisor at once would produce a shortened or stretched period. It disables the clock during a high phase and then enables it again. Gating applied at once would chop that high phase into a runt pulse, and a restart that is not aligned to a period boundary would give a short first period.

// File: rtl/tabdiv_pkg.sv
package tabdiv_pkg;
  localparam int CODE_W  = 4;
  localparam int DIV_W   = 6;
  localparam int REG_W   = 16;
  localparam int DIS_BIT = 8;
  localparam int ERR_BIT = 15;
  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(1);
  localparam logic [DIV_W-1:0]  RST_DIV  = DIV_W'(3);

  typedef struct packed {
    logic             ok;
    logic [DIV_W-1:0] div;
  } div_sel_t;

  function automatic div_sel_t decode_code(input logic [CODE_W-1:0] c);
    div_sel_t r;
    r.ok = 1'b1;
    case (c)
      4'd1:    r.div = DIV_W'(3);
      4'd2:    r.div = DIV_W'(4);
      4'd3:    r.div = DIV_W'(6);
      4'd4:    r.div = DIV_W'(8);
      4'd5:    r.div = DIV_W'(12);
      4'd6:    r.div = DIV_W'(16);
      4'd7:    r.div = DIV_W'(18);
      4'd8:    r.div = DIV_W'(24);
      4'd10:   r.div = DIV_W'(36);
      4'd11:   r.div = DIV_W'(48);
      default: begin r.ok = 1'b0; r.div = RST_DIV; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tabdiv_ctrl.sv
module tabdiv_ctrl
  import tabdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [DIV_W-1:0]  div_req,
  output logic              run_req
);
  logic [CODE_W-1:0] code_q;
  logic              dis_q;
  logic              err_q;
  div_sel_t          wr_sel;
  div_sel_t          cur_sel;
  logic              unused_bits;

  assign wr_sel      = decode_code(wr_data[CODE_W-1:0]);
  assign cur_sel     = decode_code(code_q);
  assign unused_bits = ^{wr_data[REG_W-1:DIS_BIT+1], wr_data[DIS_BIT-1:CODE_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= RST_CODE;
      dis_q  <= 1'b1;
      err_q  <= 1'b0;
    end else if (wr_en) begin
      if (wr_sel.ok) begin
        code_q <= wr_data[CODE_W-1:0];
        dis_q  <= wr_data[DIS_BIT];
      end else begin
        err_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data                 = '0;
    rd_data[CODE_W-1:0]     = code_q;
    rd_data[DIS_BIT]        = dis_q;
    rd_data[ERR_BIT]        = err_q;
  end

  assign div_req = cur_sel.div;
  assign run_req = ~dis_q;

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cur_sel.ok); // R4
  AST_INVALID_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel.ok) |=> ($stable(code_q) && $stable(dis_q))); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R5
endmodule

// File: rtl/tabdiv_gen.sv
module tabdiv_gen
  import tabdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_req,
  input  logic             run_req,
  output logic             clk_out,
  output logic             period_tick
);
  logic [DIV_W-1:0] cnt_q, div_q;
  logic             run_q;
  logic             last;
  logic [DIV_W-1:0] cnt_n, div_n;
  logic             run_n;

  assign last  = (cnt_q == div_q - DIV_W'(1));
  assign cnt_n = last ? '0 : cnt_q + DIV_W'(1);
  assign div_n = last ? div_req : div_q;
  assign run_n = last ? run_req : run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      div_q       <= RST_DIV;
      run_q       <= 1'b0;
      clk_out     <= 1'b0;
      period_tick <= 1'b0;
    end else begin
      cnt_q       <= cnt_n;
      div_q       <= div_n;
      run_q       <= run_n;
      clk_out     <= run_n && (cnt_n < (div_n >> 1));
      period_tick <= run_n && (cnt_n == '0);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_q); // R6
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> ($stable(div_q) && $stable(run_q))); // R7
  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> period_tick); // R10
  AST_TICK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |-> clk_out); // R10
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!clk_out && !period_tick)); // R8
endmodule

// File: rtl/table_clk_div.sv
module table_clk_div
  import tabdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clk_out,
  output logic             period_tick
);
  logic [DIV_W-1:0] div_req;
  logic             run_req;

  tabdiv_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .div_req (div_req),
    .run_req (run_req)
  );

  tabdiv_gen u_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_req     (div_req),
    .run_req     (run_req),
    .clk_out     (clk_out),
    .period_tick (period_tick)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!clk_out && !period_tick)); // R1
endmodule

// File: tb/table_clk_div_tb.sv
module table_clk_div_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        clk_out, period_tick;
  int          errors = 0;
  int          checks = 0;
  int          cycles = 0;

  always #5 clk = ~clk;

  table_clk_div u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_out(clk_out), .period_tick(period_tick)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int exp_div(input int c);
    case (c)
      1: return 3;   2: return 4;   3: return 6;   4: return 8;
      5: return 12;  6: return 16;  7: return 18;  8: return 24;
      10: return 36; 11: return 48;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Sync to a tick, then measure one period; optionally write at sample wr_at.
  task automatic measure(input int wr_at, input logic [15:0] d,
                         output int per, output int hi, output int tk);
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!period_tick && n < 200);
    per = 0; hi = 0; tk = 0;
    do begin
      if (clk_out) hi++;
      if (period_tick) tk++;
      per++;
      wr_en = (per == wr_at); wr_data = d;
      @(negedge clk);
    end while (!period_tick && per < 200);
    wr_en = 1'b0;
  endtask

  initial begin
    int per, hi, tk, last_code, h, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 readback", int'(rd_data), 'h0101);
    h = 0; t = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (clk_out) h++; if (period_tick) t++;
    end
    chk("R1 clk_out idle", h, 0);
    chk("R1 tick idle", t, 0);

    wr(16'h0001);
    last_code = 1;
    for (int c = 0; c < 16; c++) begin
      if (exp_div(c) != 0) begin
        wr(16'(c));
        last_code = c;
        measure(0, '0, per, hi, tk);
        measure(0, '0, per, hi, tk);
        chk(c <= 4 ? "R2 period" : "R3 period", per, exp_div(c));
        chk("R6 high time", hi, exp_div(c) / 2);
        chk("R10 ticks per period", tk, 1);
        chk("R2 readback code", int'(rd_data[3:0]), c);
      end else begin
        wr(16'h0100 | 16'(c));
        chk("R4 code kept", int'(rd_data[3:0]), last_code);
        chk("R4 disable kept", int'(rd_data[8]), 0);
        chk("R5 error flag", int'(rd_data[15]), 1);
        measure(0, '0, per, hi, tk);
        chk("R4 period kept", per, exp_div(last_code));
      end
    end
    chk("R5 readback layout", int'(rd_data), 'h8000 | last_code);

    // R7 reprogram mid-period, 48 -> 3
    wr(16'h000B);
    measure(0, '0, per, hi, tk);
    measure(5, 16'h0001, per, hi, tk);
    chk("R7 old period finishes", per, 48);
    chk("R7 old high time", hi, 24);
    measure(0, '0, per, hi, tk);
    chk("R7 new period", per, 3);
    chk("R6 odd high", hi, 1);
    // R7 3 -> 48
    measure(1, 16'h000B, per, hi, tk);
    chk("R7 short old period", per, 3);
    measure(0, '0, per, hi, tk);
    chk("R7 long new period", per, 48);

    // R8 disable during high phase at divide-by-4
    wr(16'h0002);
    measure(0, '0, per, hi, tk);
    do @(negedge clk); while (!period_tick);
    wr_en = 1'b1; wr_data = 16'h0102;
    h = 0; t = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); wr_en = 1'b0;
      if (clk_out) h++; if (period_tick) t++;
    end
    chk("R8 high phase not cut", h, 1);
    chk("R8 no tick while stopped", t, 0);
    chk("R8 disable readback", int'(rd_data[8]), 1);

    // R9 re-enable
    wr(16'h0002);
    measure(0, '0, per, hi, tk);
    chk("R9 first period full", per, 4);
    chk("R9 first high full", hi, 2);
    chk("R10 tick once", tk, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule